// File: doc/BRIEF.md
# Pin Port Configuration Bank

This block controls one port of general-purpose pins (32 by default). It holds a bank of per-pin control words on a simple write/read register bus and turns them into pad controls for each pin: drive value, drive enable, pull-up, pull-down and bus keeper. A pin is either in software mode or in peripheral mode. In software mode its drive comes from the bank's own value and enable words. In peripheral mode one of eight peripheral functions drives it, and three bit-planes of function select pick that function.

The control words cannot be written plainly. Each one sits in a 16-byte group with four word addresses. The word at +0x0 only reads. The words at +0x4, +0x8 and +0xC set, clear and invert the bits given as 1, so software never needs a read-modify-write. The pad inputs pass through a two-flop synchronizer into a read-only level word. Open-drain pins are built in software: the drive value is held at 0 and the drive enable is switched.

Group map (address bits 7:4): 0 mode (1 = software mode), 1 drive enable, 2 drive value, 3 pull-up, 4 pull-down, 5/6/7 function-select planes 0/1/2, 8 pad level (read-only).

Top module: `pinbank_port`

## Requirements
- R1: After reset the mode word is all ones and every other control word is zero, so every pin is an undriven input in software mode.
- R2: A write to group offset 0x4 sets the register bits written as 1 and leaves the others unchanged.
- R3: A write to group offset 0x8 clears the bits written as 1 and leaves the others unchanged.
- R4: A write to group offset 0xC inverts the bits written as 1 and leaves the others unchanged.
- R5: Writes to offset 0x0, writes with address bits 1:0 not zero, and writes to the level group (0x80) change nothing. A read at any of the four offsets of a group returns that group's value, and a read of an unmapped group (0x90 and above) returns 0.
- R6: With the mode bit of a pin at 1, pad_out and pad_oe of that pin equal its drive-value and drive-enable bits.
- R7: With the mode bit of a pin at 0, the pin takes pad_out and pad_oe from peripheral function k = {plane2, plane1, plane0}. Function k of pin i sits at bit k*NPIN+i of fn_out and fn_oe.
- R8: Pull-up alone asserts pad_pu, pull-down alone asserts pad_pd, and both together assert pad_keep only. At most one of the three is high for any pin.
- R9: A change on pad_in shows in the level word (group 8) after the second rising clock edge, and not after the first.
- R10: Open-drain use works in software mode. With the drive value at 0, toggling the drive enable flips pad_oe while pad_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address: group in bits 7:4, alias in bits 3:2 |
| bus_wdata | input | NPIN | Write bit mask |
| bus_rdata | output | NPIN | Combinational read of the addressed group |
| pad_in | input | NPIN | Asynchronous pad input levels |
| fn_out | input | 8*NPIN | Peripheral drive values, function k at bits k*NPIN +: NPIN |
| fn_oe | input | 8*NPIN | Peripheral drive enables, same layout |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad drive enable |
| pad_pu | output | NPIN | Pull-up enable |
| pad_pd | output | NPIN | Pull-down enable |
| pad_keep | output | NPIN | Bus keeper enable |

## Verification
The alias logic is driven with random masks on random groups and offsets, and every readback is compared with a bench model. This catches a swapped set/clear/invert decode, a plain write that leaks through, and bits outside the mask that get disturbed. The pad mux is checked with a random mix of mode bits and all eight function codes against fresh random peripheral vectors, which tells a wrong select-plane order from a wrong ownership choice. Directed cases cover the reset values, each pull combination including the keeper, open-drain toggling, misaligned writes, and the cycle on which a pad change first shows in the level word.

// File: rtl/pinbank_pkg.sv
// Shared constants for the pin port configuration bank.
// Assumes 16-byte register groups with four 32-bit word aliases each.
package pinbank_pkg;
    localparam int SELW   = 3;           // function-select planes
    localparam int NCFG   = 8;           // writable control words
    localparam int GRP_W  = 4;           // group index width
    localparam int GRP_MODE = 0;
    localparam int GRP_DEN  = 1;
    localparam int GRP_DVAL = 2;
    localparam int GRP_PU   = 3;
    localparam int GRP_PD   = 4;
    localparam int GRP_SEL0 = 5;
    localparam int GRP_LVL  = 8;

    typedef enum logic [1:0] {
        AL_VALUE = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TGL   = 2'd3
    } alias_e;
endpackage

// File: rtl/pinbank_cfg_reg.sv
// One control word with set, clear and invert write strobes.
// Assumes at most one strobe is active in a cycle (guaranteed by the decoder).
module pinbank_cfg_reg #(
    parameter int          W        = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic         tgl_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    // Purpose: apply the masked set/clear/invert update to the word.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (set_en) q <= q | mask;
        else if (clr_en) q <= q & ~mask;
        else if (tgl_en) q <= q ^ mask;
    end

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(mask)) == $past(mask)) && ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(mask)) == '0) && ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
    a_r4_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_en |=> (q == ($past(q) ^ $past(mask))));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en || tgl_en) |=> $stable(q));
endmodule

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for the asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: two register stages from the pad to the level word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/pinbank_pin_mux.sv
// Per-pin output ownership and pull decode.
// Assumes NFUNC = 2**SELW peripheral functions per pin.
module pinbank_pin_mux #(
    parameter int SELW  = 3,
    localparam int NFUNC = 1 << SELW
) (
    input  logic             sw_mode,
    input  logic             dval,
    input  logic             den,
    input  logic [SELW-1:0]  sel,
    input  logic [NFUNC-1:0] fo,
    input  logic [NFUNC-1:0] foe,
    input  logic             pu,
    input  logic             pd,
    output logic             out,
    output logic             oe,
    output logic             pu_o,
    output logic             pd_o,
    output logic             keep_o
);
    // Purpose: pick the software drive or the selected peripheral drive.
    always_comb begin
        if (sw_mode) begin
            out = dval;
            oe  = den;
        end else begin
            out = fo[sel];
            oe  = foe[sel];
        end
    end

    // Purpose: turn the two pull bits into pull-up, pull-down or keeper.
    always_comb begin
        pu_o   = pu & ~pd;
        pd_o   = pd & ~pu;
        keep_o = pu & pd;
    end
endmodule

// File: rtl/pinbank_port.sv
// Top of the pin port configuration bank: address decode, control words,
// input synchronizer and per-pin pad muxes.
// Assumes a single-cycle write strobe and a combinational read path.
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8,
    localparam int NFUNC = 1 << SELW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NPIN-1:0]       bus_wdata,
    output logic [NPIN-1:0]       bus_rdata,
    input  logic [NPIN-1:0]       pad_in,
    input  logic [NFUNC*NPIN-1:0] fn_out,
    input  logic [NFUNC*NPIN-1:0] fn_oe,
    output logic [NPIN-1:0]       pad_out,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NPIN-1:0]       pad_pu,
    output logic [NPIN-1:0]       pad_pd,
    output logic [NPIN-1:0]       pad_keep
);
    logic [GRP_W-1:0] grp;
    alias_e           al;
    logic             wr_ok;
    logic [NPIN-1:0]  cfg [NCFG];
    logic [NPIN-1:0]  level;

    // Purpose: split the byte address into group, alias and alignment check.
    always_comb begin
        grp   = bus_addr[7:4];
        al    = alias_e'(bus_addr[3:2]);
        wr_ok = bus_wr && (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:8] == '0);
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam logic [NPIN-1:0] RV = (g == GRP_MODE) ? '1 : '0;
        logic hit;
        assign hit = wr_ok && (grp == GRP_W'(g));
        pinbank_cfg_reg #(.W(NPIN), .RST_VAL(RV)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (hit && (al == AL_SET)),
            .clr_en (hit && (al == AL_CLR)),
            .tgl_en (hit && (al == AL_TGL)),
            .mask   (bus_wdata),
            .q      (cfg[g])
        );
    end

    pinbank_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level)
    );

    // Purpose: return the addressed group, the level word, or zero.
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NCFG; g++)
            if (grp == GRP_W'(g)) bus_rdata = cfg[g];
        if (grp == GRP_W'(GRP_LVL)) bus_rdata = level;
        if (bus_addr[ADDR_W-1:8] != '0) bus_rdata = '0;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [NFUNC-1:0] fo, foe;
        logic [SELW-1:0]  sel;
        for (genvar k = 0; k < NFUNC; k++) begin : g_fn
            assign fo[k]  = fn_out[k*NPIN + i];
            assign foe[k] = fn_oe[k*NPIN + i];
        end
        for (genvar p = 0; p < SELW; p++) begin : g_plane
            assign sel[p] = cfg[GRP_SEL0 + p][i];
        end
        pinbank_pin_mux #(.SELW(SELW)) u_mux (
            .sw_mode (cfg[GRP_MODE][i]),
            .dval    (cfg[GRP_DVAL][i]),
            .den     (cfg[GRP_DEN][i]),
            .sel     (sel),
            .fo      (fo),
            .foe     (foe),
            .pu      (cfg[GRP_PU][i]),
            .pd      (cfg[GRP_PD][i]),
            .out     (pad_out[i]),
            .oe      (pad_oe[i]),
            .pu_o    (pad_pu[i]),
            .pd_o    (pad_pd[i]),
            .keep_o  (pad_keep[i])
        );
    end

    a_r6_sw_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg[GRP_MODE] & (pad_out ^ cfg[GRP_DVAL])) == '0) &&
        ((cfg[GRP_MODE] & (pad_oe ^ cfg[GRP_DEN])) == '0));
    a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0) && ((pad_keep & (pad_pu | pad_pd)) == '0));
    a_r1_reset_mode: assert property (@(posedge clk)
        !rst_n |=> (cfg[GRP_MODE] == '1) && (pad_oe == '0 || !rst_n));
endmodule

// File: tb/pinbank_port_bench.sv
`timescale 1ns/1ps
module pinbank_port_bench;
    localparam int NPIN = 32;
    localparam int NF   = 8;

    logic clk = 0, rst_n = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [NPIN-1:0] bus_wdata = 0, bus_rdata, pad_in = 0;
    logic [NF*NPIN-1:0] fn_out = 0, fn_oe = 0;
    logic [NPIN-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_keep;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [NPIN-1:0] m [8];

    always #2.5 clk = ~clk;

    pinbank_port u_pinbank_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_keep(pad_keep));

    task automatic check(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one write for one cycle and update the bench model.
    task automatic wr(logic [7:0] a, logic [NPIN-1:0] d);
        int g = a[7:4];
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        if (g < 8 && a[1:0] == 2'b00) begin
            case (a[3:2])
                2'd1: m[g] = m[g] | d;
                2'd2: m[g] = m[g] & ~d;
                2'd3: m[g] = m[g] ^ d;
                default: ;
            endcase
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [NPIN-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [NPIN-1:0] exp_out(bit want_oe);
        logic [NPIN-1:0] r;
        for (int i = 0; i < NPIN; i++) begin
            int k = {m[7][i], m[6][i], m[5][i]};
            if (m[0][i]) r[i] = want_oe ? m[1][i] : m[2][i];
            else         r[i] = want_oe ? fn_oe[k*NPIN+i] : fn_out[k*NPIN+i];
        end
        return r;
    endfunction

    task automatic check_pads(string tag);
        #0.5;
        check({tag, " R6/R7 pad_out"}, pad_out, exp_out(0));
        check({tag, " R6/R7 pad_oe"},  pad_oe,  exp_out(1));
        check({tag, " R8 pu"},   pad_pu,   m[3] & ~m[4]);
        check({tag, " R8 pd"},   pad_pd,   m[4] & ~m[3]);
        check({tag, " R8 keep"}, pad_keep, m[3] & m[4]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NPIN-1:0] v;
        void'($urandom(32'd4242));
        for (int g = 0; g < 8; g++) m[g] = (g == 0) ? '1 : '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values
        for (int g = 0; g < 8; g++) begin
            rd(8'(g << 4), v);
            check($sformatf("R1 reset group %0d", g), v, m[g]);
        end
        check_pads("R1");

        // R2, R3, R4 directed
        wr(8'h24, 32'h0000_FF0F); rd(8'h20, v); check("R2 set", v, 32'h0000_FF0F);
        wr(8'h28, 32'h0000_0F01); rd(8'h20, v); check("R3 clear", v, 32'h0000_F00E);
        wr(8'h2C, 32'hF000_00FF); rd(8'h20, v); check("R4 toggle", v, 32'hF000_F0F1);

        // R5: ignored writes, alias reads, unmapped reads
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); check("R5 plain write ignored", v, m[2]);
        wr(8'h25, 32'hFFFF_FFFF); rd(8'h2C, v); check("R5 misaligned ignored", v, m[2]);
        rd(8'h28, v); check("R5 alias read", v, m[2]);
        rd(8'h90, v); check("R5 unmapped read", v, '0);

        // R9: synchronizer latency
        @(negedge clk); pad_in = 32'hA5A5_0F0F;
        @(negedge clk); rd(8'h80, v); check("R9 after one edge", v, '0);
        @(negedge clk); rd(8'h80, v); check("R9 after two edges", v, 32'hA5A5_0F0F);
        wr(8'h84, 32'hFFFF_FFFF); rd(8'h80, v); check("R5 level write ignored", v, 32'hA5A5_0F0F);

        // R8: pull combinations on pins 0,1,2
        wr(8'h34, 32'h5); wr(8'h44, 32'h6);
        check_pads("R8 directed");

        // R10: open drain on pin 3
        wr(8'h28, 32'h8); wr(8'h1C, 32'h8); #0.5;
        check("R10 od oe on", pad_oe & 32'h8, 32'h8);
        check("R10 od out low", pad_out & 32'h8, 32'h0);
        wr(8'h1C, 32'h8); #0.5;
        check("R10 od oe off", pad_oe & 32'h8, 32'h0);

        // R7: each function code on pin 4 in peripheral mode
        wr(8'h08, 32'h10);
        for (int k = 0; k < 8; k++) begin
            wr(8'h58, 32'h10); wr(8'h68, 32'h10); wr(8'h78, 32'h10);
            if (k[0]) wr(8'h54, 32'h10);
            if (k[1]) wr(8'h64, 32'h10);
            if (k[2]) wr(8'h74, 32'h10);
            @(negedge clk);
            fn_out = '0; fn_oe = '0;
            fn_out[k*NPIN+4] = 1'b1;
            fn_oe[k*NPIN+4]  = 1'b1;
            #0.5;
            check($sformatf("R7 function %0d out", k), pad_out & 32'h10, 32'h10);
            check($sformatf("R7 function %0d oe", k),  pad_oe & 32'h10, 32'h10);
        end

        // Random mix: R2-R8
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            a = {4'($urandom_range(0, 9)), 2'($urandom_range(0, 3)), 2'b00};
            if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
            wr(a, $urandom);
            @(negedge clk);
            fn_out = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            fn_oe  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            rd({a[7:4], 2'($urandom_range(0, 3)), 2'b00}, v);
            if (a[7:4] < 8) check("R2/R3/R4/R5 random readback", v, m[a[7:4]]);
            check_pads("random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule